// File: doc/BRIEF.md
# Split Dual 8-bit Reload Timer

This block is a timer built from two independent 8-bit up-counters, a low byte and a high byte. Each byte carries its own reload value, sticky overflow flag and tick-source choice. A byte either steps on every system clock, or on a divided tick. The divided tick comes from a divide-by-12 of the system clock, or from a divide-by-8 of an external clock that is first synchronized into the system clock domain. A single external-select input picks between the two divided sources, and each byte's own fast-mode bit overrides that choice.

When a byte steps from 0xFF it loads its reload value rather than going to zero. On that wrap it sets its flag and emits a one-cycle overflow pulse, which other blocks can use as a tick. The flags stay set until software clears them with a strobe. The interrupt request is driven from the high-byte flag, and optionally also from the low-byte flag. The run input stops only the high byte.

Top module: `dual_byte_timer`

## Requirements
- R1: While reset is high and in the first cycle after it is released, both counts read 0x00, both flags and both overflow pulses are 0, and the interrupt request is 0.
- R2: A byte whose fast-mode input is 1 advances by one on every system clock edge, whatever the external-select input says.
- R3: A byte whose fast-mode input is 0 while external-select is 0 advances by exactly one per 12 system clocks.
- R4: A byte whose fast-mode input is 0 while external-select is 1 advances by exactly one per 8 rising edges of the external clock.
- R5: When a byte steps while its count is 0xFF, its count becomes its reload input value. Its overflow pulse output is 1 for exactly the following cycle.
- R6: A byte's flag becomes 1 on that byte's wrap and stays 1 until its clear strobe is 1 for a cycle with no wrap. After that cycle it reads 0. A clear strobe has no effect on the other byte's flag.
- R7: If a byte wraps in the same cycle that its clear strobe is 1, its flag reads 1 afterwards.
- R8: The interrupt output equals irq_en_i AND (hi_flag_o OR (lo_irq_en_i AND lo_flag_o)).
- R9: While run_i is 0 the high count holds its value, and the low count keeps advancing at its selected rate.
- R10: After a wrap that loads reload value V, the next wrap of that byte occurs after exactly 256 − V further steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External clock, asynchronous to clk |
| run_i | input | 1 | Enables stepping of the high byte |
| lo_fast_i | input | 1 | Low byte steps every system clock when 1 |
| hi_fast_i | input | 1 | High byte steps every system clock when 1 |
| ext_sel_i | input | 1 | Divided source: 0 = system/12, 1 = external/8 |
| irq_en_i | input | 1 | Master interrupt enable |
| lo_irq_en_i | input | 1 | Lets the low-byte flag raise the interrupt |
| lo_reload_i | input | 8 | Low-byte reload value |
| hi_reload_i | input | 8 | High-byte reload value |
| lo_clr_i | input | 1 | Clear strobe for the low-byte flag |
| hi_clr_i | input | 1 | Clear strobe for the high-byte flag |
| lo_count_o | output | 8 | Low-byte count |
| hi_count_o | output | 8 | High-byte count |
| lo_flag_o | output | 1 | Sticky low-byte overflow flag |
| hi_flag_o | output | 1 | Sticky high-byte overflow flag |
| lo_ovf_pulse_o | output | 1 | One-cycle low-byte overflow tick |
| hi_ovf_pulse_o | output | 1 | One-cycle high-byte overflow tick |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures step rates over windows that are exact multiples of each divider period. A prescaler that is off by one, or a synchronizer that counts both edges of the external clock, shows up as a wrong count delta. It times the gap between successive wraps after a non-zero reload, which catches a byte that passes through zero or loads the reload value one step late. It asserts a clear strobe in the exact cycle the count sits at 0xFF; a design that lets the clear win would lose that overflow. It also walks the interrupt enables through every combination, and stops the high byte while the low byte keeps running, to catch run gating applied to the wrong byte.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    localparam int BYTE_LO = 0;
    localparam int BYTE_HI = 1;
    localparam int N_BYTES = 2;

    typedef enum logic [1:0] {
        SRC_SYS  = 2'd0,
        SRC_DIV  = 2'd1,
        SRC_EXT  = 2'd2
    } tick_src_e;

    typedef struct packed {
        logic sys;
        logic div;
        logic ext;
    } tick_bus_t;

    function automatic tick_src_e pick_source(input logic fast, input logic ext_sel);
        if (fast)
            return SRC_SYS;
        else if (ext_sel)
            return SRC_EXT;
        else
            return SRC_DIV;
    endfunction

endpackage

// File: rtl/dbt_tick_gen.sv
module dbt_tick_gen
    import dbt_pkg::*;
#(
    parameter int SYS_DIV     = 12,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ext_clk_i,
    output tick_bus_t ticks_o
);
    localparam int SYS_W = $clog2(SYS_DIV);
    localparam int EXT_W = $clog2(EXT_DIV);
    localparam logic [SYS_W-1:0] SYS_LAST = SYS_W'(SYS_DIV - 1);
    localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(EXT_DIV - 1);

    logic [SYS_W-1:0]       sys_pre;
    logic [EXT_W-1:0]       ext_pre;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_prev;
    logic                   ext_rise;

    // system clock prescaler
    always_ff @(posedge clk) begin
        if (rst)
            sys_pre <= '0;
        else if (sys_pre == SYS_LAST)
            sys_pre <= '0;
        else
            sys_pre <= sys_pre + SYS_W'(1);
    end

    // external clock synchronizer and edge detect
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            ext_prev <= 1'b0;
        end else begin
            sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
            ext_prev <= sync_q[SYNC_STAGES-1];
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev;

    // external edge divider
    always_ff @(posedge clk) begin
        if (rst)
            ext_pre <= '0;
        else if (ext_rise) begin
            if (ext_pre == EXT_LAST)
                ext_pre <= '0;
            else
                ext_pre <= ext_pre + EXT_W'(1);
        end
    end

    always_comb begin
        ticks_o.sys = 1'b1;
        ticks_o.div = (sys_pre == SYS_LAST);
        ticks_o.ext = ext_rise && (ext_pre == EXT_LAST);
    end

endmodule

// File: rtl/dbt_byte_counter.sv
module dbt_byte_counter
    import dbt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tick_bus_t        ticks_i,
    input  logic             fast_i,
    input  logic             ext_sel_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             pulse_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    tick_src_e src;
    logic      src_tick;
    logic      step;
    logic      wrap;

    always_comb begin
        src = pick_source(fast_i, ext_sel_i);
        unique case (src)
            SRC_SYS: src_tick = ticks_i.sys;
            SRC_EXT: src_tick = ticks_i.ext;
            default: src_tick = ticks_i.div;
        endcase
        step = en_i & src_tick;
        wrap = step && (count_o == CNT_TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
            flag_o  <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= wrap;
            if (step)
                count_o <= wrap ? reload_i : count_o + CNT_W'(1);
            // hardware set takes priority over software clear
            if (wrap)
                flag_o <= 1'b1;
            else if (clr_i)
                flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/dual_byte_timer.sv
module dual_byte_timer
    import dbt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYS_DIV     = 12,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_clk_i,
    input  logic             run_i,
    input  logic             lo_fast_i,
    input  logic             hi_fast_i,
    input  logic             ext_sel_i,
    input  logic             irq_en_i,
    input  logic             lo_irq_en_i,
    input  logic [CNT_W-1:0] lo_reload_i,
    input  logic [CNT_W-1:0] hi_reload_i,
    input  logic             lo_clr_i,
    input  logic             hi_clr_i,
    output logic [CNT_W-1:0] lo_count_o,
    output logic [CNT_W-1:0] hi_count_o,
    output logic             lo_flag_o,
    output logic             hi_flag_o,
    output logic             lo_ovf_pulse_o,
    output logic             hi_ovf_pulse_o,
    output logic             irq_o
);
    tick_bus_t              ticks;
    logic [N_BYTES-1:0]     fast_v, en_v, clr_v, flag_v, pulse_v;
    logic [CNT_W-1:0]       reload_v [N_BYTES];
    logic [CNT_W-1:0]       count_v  [N_BYTES];

    dbt_tick_gen #(
        .SYS_DIV     (SYS_DIV),
        .EXT_DIV     (EXT_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) tick_i (
        .clk       (clk),
        .rst       (rst),
        .ext_clk_i (ext_clk_i),
        .ticks_o   (ticks)
    );

    always_comb begin
        fast_v[BYTE_LO]   = lo_fast_i;
        fast_v[BYTE_HI]   = hi_fast_i;
        en_v[BYTE_LO]     = 1'b1;
        en_v[BYTE_HI]     = run_i;
        clr_v[BYTE_LO]    = lo_clr_i;
        clr_v[BYTE_HI]    = hi_clr_i;
        reload_v[BYTE_LO] = lo_reload_i;
        reload_v[BYTE_HI] = hi_reload_i;
    end

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        dbt_byte_counter #(
            .CNT_W (CNT_W)
        ) cnt_i (
            .clk       (clk),
            .rst       (rst),
            .ticks_i   (ticks),
            .fast_i    (fast_v[g]),
            .ext_sel_i (ext_sel_i),
            .en_i      (en_v[g]),
            .reload_i  (reload_v[g]),
            .clr_i     (clr_v[g]),
            .count_o   (count_v[g]),
            .flag_o    (flag_v[g]),
            .pulse_o   (pulse_v[g])
        );
    end

    assign lo_count_o     = count_v[BYTE_LO];
    assign hi_count_o     = count_v[BYTE_HI];
    assign lo_flag_o      = flag_v[BYTE_LO];
    assign hi_flag_o      = flag_v[BYTE_HI];
    assign lo_ovf_pulse_o = pulse_v[BYTE_LO];
    assign hi_ovf_pulse_o = pulse_v[BYTE_HI];
    assign irq_o = irq_en_i & (flag_v[BYTE_HI] | (lo_irq_en_i & flag_v[BYTE_LO]));

endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             run_i,
    input logic             lo_fast_i,
    input logic             irq_en_i,
    input logic             lo_clr_i,
    input logic             hi_clr_i,
    input logic [CNT_W-1:0] lo_reload_i,
    input logic [CNT_W-1:0] hi_reload_i,
    input logic [CNT_W-1:0] lo_count_o,
    input logic [CNT_W-1:0] hi_count_o,
    input logic             lo_flag_o,
    input logic             hi_flag_o,
    input logic             lo_ovf_pulse_o,
    input logic             hi_ovf_pulse_o,
    input logic             irq_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    AST_FAST_STEP: assert property (@(posedge clk) disable iff (rst)
        (lo_fast_i && lo_count_o != ALL_ONES) |=> lo_count_o == $past(lo_count_o) + CNT_W'(1)); // R2

    AST_LO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        lo_ovf_pulse_o |-> lo_count_o == $past(lo_reload_i)); // R5

    AST_HI_RELOAD: assert property (@(posedge clk) disable iff (rst)
        hi_ovf_pulse_o |-> hi_count_o == $past(hi_reload_i)); // R5

    AST_HI_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (hi_flag_o && !hi_clr_i) |=> hi_flag_o); // R6

    AST_LO_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (lo_flag_o && !lo_clr_i) |=> lo_flag_o); // R6

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (lo_ovf_pulse_o |-> lo_flag_o) and (hi_ovf_pulse_o |-> hi_flag_o)); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !irq_en_i |-> !irq_o); // R8

    AST_HI_HELD: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> $stable(hi_count_o)); // R9

endmodule

bind dual_byte_timer dbt_checker #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/dual_byte_timer_tb.sv
`timescale 1ns/1ps
module dual_byte_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_clk_i = 1'b0;
    logic       run_i, lo_fast_i, hi_fast_i, ext_sel_i, irq_en_i, lo_irq_en_i;
    logic [7:0] lo_reload_i, hi_reload_i;
    logic       lo_clr_i, hi_clr_i;
    logic [7:0] lo_count_o, hi_count_o;
    logic       lo_flag_o, hi_flag_o, lo_ovf_pulse_o, hi_ovf_pulse_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    // external clock, period 10 system clocks
    initial forever begin
        repeat (5) @(negedge clk);
        ext_clk_i = ~ext_clk_i;
    end

    dual_byte_timer dut_i (
        .clk(clk), .rst(rst), .ext_clk_i(ext_clk_i), .run_i(run_i),
        .lo_fast_i(lo_fast_i), .hi_fast_i(hi_fast_i), .ext_sel_i(ext_sel_i),
        .irq_en_i(irq_en_i), .lo_irq_en_i(lo_irq_en_i),
        .lo_reload_i(lo_reload_i), .hi_reload_i(hi_reload_i),
        .lo_clr_i(lo_clr_i), .hi_clr_i(hi_clr_i),
        .lo_count_o(lo_count_o), .hi_count_o(hi_count_o),
        .lo_flag_o(lo_flag_o), .hi_flag_o(hi_flag_o),
        .lo_ovf_pulse_o(lo_ovf_pulse_o), .hi_ovf_pulse_o(hi_ovf_pulse_o),
        .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        run_i = 0; lo_fast_i = 0; hi_fast_i = 0; ext_sel_i = 0;
        irq_en_i = 0; lo_irq_en_i = 0; lo_reload_i = 0; hi_reload_i = 0;
        lo_clr_i = 0; hi_clr_i = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic wait_lo_pulse(output int waited);
        waited = 0;
        while (!lo_ovf_pulse_o && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check(lo_count_o == 0 && hi_count_o == 0, "R1 counts", lo_count_o, 0);
        check(!lo_flag_o && !hi_flag_o, "R1 flags", lo_flag_o + hi_flag_o, 0);
        check(!lo_ovf_pulse_o && !hi_ovf_pulse_o && !irq_o, "R1 pulses/irq",
              lo_ovf_pulse_o + hi_ovf_pulse_o + irq_o, 0);
    endtask

    task automatic t_rates();
        logic [7:0] l0, h0, dl, dh;
        do_reset();
        run_i = 1;
        @(negedge clk);
        l0 = lo_count_o; h0 = hi_count_o;
        repeat (120) @(negedge clk);
        dl = lo_count_o - l0; dh = hi_count_o - h0;
        check(dl == 10, "R3 low /12", dl, 10);
        check(dh == 10, "R3 high /12", dh, 10);
        // R2 fast high byte ignores ext_sel, R4 low byte on external/8
        ext_sel_i = 1; hi_fast_i = 1;
        repeat (40) @(negedge clk);
        l0 = lo_count_o; h0 = hi_count_o;
        repeat (320) @(negedge clk);
        dl = lo_count_o - l0; dh = hi_count_o - h0;
        check(dl == 4, "R4 low ext/8", dl, 4);
        check(dh == 8'd64, "R2 high fast", dh, 64);
    endtask

    task automatic t_run_gate();
        logic [7:0] l0, h0, dl, dh;
        do_reset();
        hi_fast_i = 1; lo_fast_i = 1; run_i = 0;
        @(negedge clk);
        l0 = lo_count_o; h0 = hi_count_o;
        repeat (40) @(negedge clk);
        dl = lo_count_o - l0; dh = hi_count_o - h0;
        check(dh == 0, "R9 high held", dh, 0);
        check(dl == 40, "R9 low runs", dl, 40);
    endtask

    task automatic t_reload_flags();
        int w;
        int gap;
        do_reset();
        lo_fast_i = 1; lo_reload_i = 8'hF0;
        wait_lo_pulse(w);
        check(lo_count_o == 8'hF0, "R5 reload value", lo_count_o, 8'hF0);
        check(lo_flag_o == 1, "R6 flag set", lo_flag_o, 1);
        @(negedge clk);
        check(lo_ovf_pulse_o == 0, "R5 single cycle pulse", lo_ovf_pulse_o, 0);
        gap = 1;
        while (!lo_ovf_pulse_o && gap < 1000) begin
            @(negedge clk);
            gap++;
        end
        check(gap == 16, "R10 wrap interval", gap, 16);
        // slow the byte, flag must persist then clear on strobe
        lo_fast_i = 0; ext_sel_i = 0;
        repeat (5) @(negedge clk);
        check(lo_flag_o == 1, "R6 flag sticky", lo_flag_o, 1);
        lo_clr_i = 1;
        @(negedge clk);
        lo_clr_i = 0;
        check(lo_flag_o == 0, "R6 flag cleared", lo_flag_o, 0);
        // set wins over clear
        lo_fast_i = 1;
        w = 0;
        while (lo_count_o != 8'hFF && w < 1000) begin
            @(negedge clk);
            w++;
        end
        lo_clr_i = 1; hi_clr_i = 1;
        @(negedge clk);
        lo_clr_i = 0; hi_clr_i = 0;
        check(lo_flag_o == 1, "R7 set beats clear", lo_flag_o, 1);
        check(hi_flag_o == 0, "R6 other flag untouched", hi_flag_o, 0);
    endtask

    task automatic t_high_reload();
        int gap;
        do_reset();
        run_i = 1; hi_fast_i = 1; hi_reload_i = 8'hFE;
        gap = 0;
        while (!hi_ovf_pulse_o && gap < 1000) begin
            @(negedge clk);
            gap++;
        end
        check(hi_count_o == 8'hFE, "R5 high reload", hi_count_o, 8'hFE);
        @(negedge clk);
        gap = 1;
        while (!hi_ovf_pulse_o && gap < 1000) begin
            @(negedge clk);
            gap++;
        end
        check(gap == 2, "R10 high interval", gap, 2);
    endtask

    task automatic t_irq();
        int w;
        do_reset();
        irq_en_i = 1; lo_fast_i = 1;
        wait_lo_pulse(w);
        #1;
        check(irq_o == 0, "R8 low flag masked", irq_o, 0);
        lo_irq_en_i = 1; #1;
        check(irq_o == 1, "R8 low flag enabled", irq_o, 1);
        irq_en_i = 0; #1;
        check(irq_o == 0, "R8 master off", irq_o, 0);
        @(negedge clk);
        irq_en_i = 1; lo_irq_en_i = 0; lo_fast_i = 0;
        lo_clr_i = 1;
        @(negedge clk);
        lo_clr_i = 0;
        run_i = 1; hi_fast_i = 1;
        w = 0;
        while (!hi_ovf_pulse_o && w < 1000) begin
            @(negedge clk);
            w++;
        end
        #1;
        check(irq_o == 1, "R8 high flag irq", irq_o, 1);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_rates();
        t_run_gate();
        t_reload_flags();
        t_high_reload();
        t_irq();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule